// File: doc/BRIEF.md
# Serial Audio Frame Engine

This block moves stereo audio between a parallel sample interface and a serial audio link. The link carries one data line, a bit clock and a frame sync. On the transmit side, a left and a right sample are taken once per frame and shifted out one bit at a time. On the receive side, bits arriving on the data line are collected into a left and a right word. The words are then presented together with a one-cycle valid strobe.

A frame lasts 64 bit clocks, split into two halves of 32. The left channel goes in the half where frame sync is low, and the right channel in the half where it is high. Two framings are available. In standard I2S framing the first data bit comes one bit clock after the frame sync edge. In left-justified framing it comes on the same bit clock as the edge.

The bit clock can be generated inside the block or taken from an external codec, and the same choice is made separately for the frame sync. The core clock runs at twice the master clock rate. Each bit-clock phase lasts (divider field + 1) core cycles, so one bit clock equals (divider field + 1) master clock periods, and the frame rate is the master clock divided by 64 times the divide ratio. Externally supplied clocks are synchronised into the core clock domain before their edges are detected.

Top module: `i2s_frame_engine`

## Requirements
- R1: With a local bit clock, each high phase and each low phase of `bclk_out` lasts `cfg_div`+1 core cycles. A frame lasts 64 bit clocks, which is 128*(`cfg_div`+1) core cycles between falling edges of `fsync_out`.
- R2: `fsync_out` changes only together with a falling edge of the bit clock. It is low for the 32 bit clocks of the left half and high for the 32 bit clocks of the right half.
- R3: When `cfg_lj`=1, the channel MSB appears in the first bit clock after a frame sync change. When `cfg_lj`=0, it appears in the second bit clock. `sd_out` changes only on a bit-clock falling edge.
- R4: Size codes are 0 for 8 bits, 1 for 16 bits, 3 for 20 bits and 4 for 24 bits; any other code means 16 bits. A sample of N bits is the low N bits of its 24-bit input. It is sent MSB first, and the rest of the 32-bit half is zero.
- R5: When `cfg_mono`=1, the left sample is sent in both halves and `tx_right` has no effect on `sd_out`.
- R6: Receive data is sampled on bit-clock rising edges. The N received bits of each channel appear right-justified in `rx_left`/`rx_right` (N from `cfg_rx_size`) with upper bits zero. `rx_valid` pulses for one cycle once per frame, after the last bit of the right half.
- R7: When `cfg_bclk_local`=0, `bclk_oe` is low, `bclk_out` stays low, and all timing follows `bclk_in`. When `cfg_fsync_local`=0, `fsync_oe` is low and the slot position locks to the edges of `fsync_in`.
- R8: `sysclk_en` is high exactly when both the bit clock and the frame sync are local.
- R9: During reset, `bclk_out`, `sd_out`, `tx_take` and `rx_valid` are 0.
- R10: `tx_take` pulses for one cycle once per frame, marking the moment `tx_left`/`tx_right` are captured for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the master clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lj | input | 1 | 1 = left-justified framing, 0 = I2S framing |
| cfg_bclk_local | input | 1 | 1 = generate the bit clock locally |
| cfg_fsync_local | input | 1 | 1 = generate the frame sync locally |
| cfg_div | input | DIV_W | Divide ratio minus one |
| cfg_tx_size | input | 3 | Transmit sample size code |
| cfg_rx_size | input | 3 | Receive sample size code |
| cfg_mono | input | 1 | Send the left sample in both halves |
| tx_left | input | 24 | Left transmit sample, right-justified |
| tx_right | input | 24 | Right transmit sample, right-justified |
| tx_take | output | 1 | Transmit samples captured this cycle |
| sd_in | input | 1 | Serial data in |
| bclk_in | input | 1 | External bit clock |
| fsync_in | input | 1 | External frame sync |
| sd_out | output | 1 | Serial data out |
| bclk_out | output | 1 | Local bit clock |
| bclk_oe | output | 1 | Bit clock output enable |
| fsync_out | output | 1 | Local frame sync |
| fsync_oe | output | 1 | Frame sync output enable |
| sysclk_en | output | 1 | System clock toward the codec enabled |
| rx_left | output | 24 | Received left word |
| rx_right | output | 24 | Received right word |
| rx_valid | output | 1 | Received pair valid for one cycle |

## Verification
The bench loops serial data back and compares every bit of whole frames with a bit-level model. Both framings are covered: a design that ignored the one-clock I2S delay would shift every channel by one bit and lose its LSB. Transmit inputs carry set bits above the chosen size, and receive is also run narrower than transmit, so a design that failed to mask or to right-justify would return wrong words. The divider is tested at 0 and at its maximum, mono is run with a right sample that must not appear, and a slave run checks that externally driven clocks are followed and that the frame position locks.

// File: rtl/i2s_fe_pkg.sv
package i2s_fe_pkg;
    localparam int SAMPLE_W = 24;
    localparam int SLOT_W   = 6;

    function automatic logic [4:0] size_to_bits(input logic [2:0] code);
        case (code)
            3'd0:    return 5'd8;
            3'd1:    return 5'd16;
            3'd3:    return 5'd20;
            3'd4:    return 5'd24;
            default: return 5'd16;
        endcase
    endfunction
endpackage

// File: rtl/i2s_fe_clkgen.sv
module i2s_fe_clkgen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_bclk_local,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             bclk_in,
    input  logic             fsync_in,
    input  logic             sd_in,
    output logic             bclk_q,
    output logic             rise_evt,
    output logic             fall_evt,
    output logic             fsync_smp,
    output logic             sd_smp
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             bclk;
        logic [2:0]       sb;
        logic [1:0]       sf;
        logic [1:0]       sdd;
    } clk_st_t;

    clk_st_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        rise_evt = 1'b0;
        fall_evt = 1'b0;
        st_d.sb  = {st_q.sb[1:0], bclk_in};
        st_d.sf  = {st_q.sf[0], fsync_in};
        st_d.sdd = {st_q.sdd[0], sd_in};
        if (cfg_bclk_local) begin
            if (st_q.cnt >= cfg_div) begin
                st_d.cnt  = '0;
                st_d.bclk = ~st_q.bclk;
                rise_evt  = ~st_q.bclk;
                fall_evt  = st_q.bclk;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt  = '0;
            st_d.bclk = 1'b0;
            rise_evt  = st_q.sb[1] & ~st_q.sb[2];
            fall_evt  = ~st_q.sb[1] & st_q.sb[2];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk_q    = st_q.bclk;
    assign fsync_smp = st_q.sf[1];
    assign sd_smp    = cfg_bclk_local ? sd_in : st_q.sdd[1];

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bclk_local && $stable(cfg_div)) |-> (st_q.cnt <= cfg_div)); // R1
endmodule

// File: rtl/i2s_fe_slot.sv
module i2s_fe_slot
    import i2s_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_fsync_local,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              fsync_smp,
    output logic [SLOT_W-1:0] slot_q
);
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic              fs_prev;
    } slot_st_t;

    slot_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (fall_evt) st_d.slot = st_q.slot + 1'b1;
        if (rise_evt) begin
            st_d.fs_prev = fsync_smp;
            if (!cfg_fsync_local && (fsync_smp != st_q.fs_prev))
                st_d.slot = {fsync_smp, {(SLOT_W-1){1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.slot    <= '1;
            st_q.fs_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_q = st_q.slot;

    AST_FS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fsync_local && !$stable(slot_q[SLOT_W-1])) |-> $past(fall_evt)); // R2
endmodule

// File: rtl/i2s_fe_tx.sv
module i2s_fe_tx
    import i2s_fe_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fall_evt,
    input  logic [SLOT_W-1:0]   slot_q,
    input  logic                cfg_lj,
    input  logic                cfg_mono,
    input  logic [2:0]          cfg_size,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic                sd_out,
    output logic                tx_take
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] l;
        logic [SAMPLE_W-1:0] r;
        logic                sd;
        logic                take;
    } tx_st_t;

    tx_st_t st_q, st_d;
    logic [SLOT_W-1:0]   pos;
    logic [4:0]          nbits, idx, sel;
    logic [SAMPLE_W-1:0] samp;
    logic                bit_v;

    always_comb begin
        st_d      = st_q;
        st_d.take = 1'b0;
        pos   = slot_q + 1'b1 - {{(SLOT_W-1){1'b0}}, ~cfg_lj};
        idx   = pos[4:0];
        nbits = size_to_bits(cfg_size);
        sel   = nbits - 5'd1 - idx;
        samp  = (pos[SLOT_W-1] && !cfg_mono) ? st_q.r : st_q.l;
        bit_v = (idx < nbits) ? samp[sel] : 1'b0;
        if (fall_evt) begin
            st_d.sd = bit_v;
            if (pos == '1) begin
                st_d.l    = tx_left;
                st_d.r    = tx_right;
                st_d.take = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sd_out  = st_q.sd;
    assign tx_take = st_q.take;

    AST_TAKE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |=> !tx_take); // R10
endmodule

// File: rtl/i2s_fe_rx.sv
module i2s_fe_rx
    import i2s_fe_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise_evt,
    input  logic [SLOT_W-1:0]   slot_q,
    input  logic                sd_smp,
    input  logic                cfg_lj,
    input  logic [2:0]          cfg_size,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                rx_valid
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] sr;
        logic [SAMPLE_W-1:0] hold;
        logic [SAMPLE_W-1:0] rl;
        logic [SAMPLE_W-1:0] rr;
        logic                valid;
    } rx_st_t;

    rx_st_t st_q, st_d;
    logic [SLOT_W-1:0]   pos;
    logic [4:0]          idx;
    logic [SAMPLE_W-1:0] sr_n;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        pos  = slot_q - {{(SLOT_W-1){1'b0}}, ~cfg_lj};
        idx  = pos[4:0];
        sr_n = st_q.sr;
        if (idx < size_to_bits(cfg_size))
            sr_n = (idx == 5'd0) ? {{(SAMPLE_W-1){1'b0}}, sd_smp}
                                 : {st_q.sr[SAMPLE_W-2:0], sd_smp};
        if (rise_evt) begin
            st_d.sr = sr_n;
            if (pos == SLOT_W'(31)) st_d.hold = sr_n;
            if (pos == '1) begin
                st_d.rl    = st_q.hold;
                st_d.rr    = sr_n;
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_left  = st_q.rl;
    assign rx_right = st_q.rr;
    assign rx_valid = st_q.valid;

    AST_RX_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R6
endmodule

// File: rtl/i2s_frame_engine.sv
module i2s_frame_engine
    import i2s_fe_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_lj,
    input  logic                cfg_bclk_local,
    input  logic                cfg_fsync_local,
    input  logic [DIV_W-1:0]    cfg_div,
    input  logic [2:0]          cfg_tx_size,
    input  logic [2:0]          cfg_rx_size,
    input  logic                cfg_mono,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic                tx_take,
    input  logic                sd_in,
    input  logic                bclk_in,
    input  logic                fsync_in,
    output logic                sd_out,
    output logic                bclk_out,
    output logic                bclk_oe,
    output logic                fsync_out,
    output logic                fsync_oe,
    output logic                sysclk_en,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                rx_valid
);
    logic              rise_evt, fall_evt, fsync_smp, sd_smp;
    logic [SLOT_W-1:0] slot_q;

    i2s_fe_clkgen #(.DIV_W(DIV_W)) clkgen_i (
        .clk(clk), .rst_n(rst_n), .cfg_bclk_local(cfg_bclk_local),
        .cfg_div(cfg_div), .bclk_in(bclk_in), .fsync_in(fsync_in),
        .sd_in(sd_in), .bclk_q(bclk_out), .rise_evt(rise_evt),
        .fall_evt(fall_evt), .fsync_smp(fsync_smp), .sd_smp(sd_smp));

    i2s_fe_slot slot_i (
        .clk(clk), .rst_n(rst_n), .cfg_fsync_local(cfg_fsync_local),
        .rise_evt(rise_evt), .fall_evt(fall_evt), .fsync_smp(fsync_smp),
        .slot_q(slot_q));

    i2s_fe_tx tx_i (
        .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .slot_q(slot_q),
        .cfg_lj(cfg_lj), .cfg_mono(cfg_mono), .cfg_size(cfg_tx_size),
        .tx_left(tx_left), .tx_right(tx_right), .sd_out(sd_out),
        .tx_take(tx_take));

    i2s_fe_rx rx_i (
        .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .slot_q(slot_q),
        .sd_smp(sd_smp), .cfg_lj(cfg_lj), .cfg_size(cfg_rx_size),
        .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid));

    assign fsync_out = slot_q[SLOT_W-1];
    assign bclk_oe   = cfg_bclk_local;
    assign fsync_oe  = cfg_fsync_local;
    assign sysclk_en = cfg_bclk_local & cfg_fsync_local;

    AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd_out) |-> $past(fall_evt)); // R3
    AST_SLAVE_BCLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_bclk_local && $past(!cfg_bclk_local)) |-> !bclk_out); // R7
endmodule

// File: tb/i2s_frame_engine_tb_top.sv
module i2s_frame_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_lj, cfg_bclk_local, cfg_fsync_local, cfg_mono;
    logic [3:0]  cfg_div;
    logic [2:0]  cfg_tx_size, cfg_rx_size;
    logic [23:0] tx_left, tx_right, rx_left, rx_right;
    logic        tx_take, sd_in, bclk_in, fsync_in, sd_out, bclk_out, bclk_oe;
    logic        fsync_out, fsync_oe, sysclk_en, rx_valid;
    logic        loop_en, gen_sd;

    int n_chk = 0, n_bad = 0, cap_n = 0;
    logic [23:0] cap_l, cap_r;
    bit done = 0;

    always #10 clk = ~clk;

    assign sd_in = loop_en ? sd_out : gen_sd;

    i2s_frame_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_lj(cfg_lj), .cfg_bclk_local(cfg_bclk_local),
        .cfg_fsync_local(cfg_fsync_local), .cfg_div(cfg_div),
        .cfg_tx_size(cfg_tx_size), .cfg_rx_size(cfg_rx_size), .cfg_mono(cfg_mono),
        .tx_left(tx_left), .tx_right(tx_right), .tx_take(tx_take), .sd_in(sd_in),
        .bclk_in(bclk_in), .fsync_in(fsync_in), .sd_out(sd_out), .bclk_out(bclk_out),
        .bclk_oe(bclk_oe), .fsync_out(fsync_out), .fsync_oe(fsync_oe),
        .sysclk_en(sysclk_en), .rx_left(rx_left), .rx_right(rx_right),
        .rx_valid(rx_valid));

    always @(negedge clk) begin
        if (rx_valid) begin
            cap_l = rx_left;
            cap_r = rx_right;
            cap_n++;
        end
    end

    typedef struct packed {
        logic        lj;
        logic        mono;
        logic [2:0]  txs;
        logic [2:0]  rxs;
        logic [3:0]  div;
        logic [23:0] l;
        logic [23:0] r;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 3'd1, 3'd1, 4'd1,  24'hFFA5C3, 24'h001234},
        '{1'b1, 1'b0, 3'd4, 3'd4, 4'd0,  24'h8F0F01, 24'h7E1337},
        '{1'b0, 1'b0, 3'd0, 3'd0, 4'd3,  24'hFFFFC6, 24'hABCD39},
        '{1'b1, 1'b0, 3'd3, 3'd3, 4'd15, 24'hFABCDE, 24'h054321},
        '{1'b0, 1'b1, 3'd4, 3'd4, 4'd2,  24'h5A5A5A, 24'hFFFFFF},
        '{1'b0, 1'b0, 3'd4, 3'd1, 4'd1,  24'hC0FFEE, 24'h123456}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int bits_of(input logic [2:0] code);
        case (code)
            3'd0: return 8;
            3'd3: return 20;
            3'd4: return 24;
            default: return 16;
        endcase
    endfunction

    function automatic longint rx_model(input logic [23:0] s, input int ntx, input int nrx);
        longint w;
        w = (longint'(s) & ((64'd1 << ntx) - 1)) << (32 - ntx);
        return w >> (32 - nrx);
    endfunction

    function automatic logic tx_bit(input logic [23:0] s, input int n, input int idx);
        if (idx >= 0 && idx < n) return s[n-1-idx];
        return 1'b0;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_lj = 1'b0; cfg_bclk_local = 1'b1; cfg_fsync_local = 1'b1;
        cfg_mono = 1'b0; cfg_div = 4'd1; cfg_tx_size = 3'd1; cfg_rx_size = 3'd1;
        tx_left = '0; tx_right = '0; bclk_in = 1'b0; fsync_in = 1'b1;
        loop_en = 1'b1; gen_sd = 1'b0;

        // R9: reset state
        repeat (3) @(negedge clk);
        check(bclk_out == 1'b0 && sd_out == 1'b0, "R9", "bclk/sd in reset",
              {bclk_out, sd_out}, 0);
        check(rx_valid == 1'b0 && tx_take == 1'b0, "R9", "strobes in reset",
              {rx_valid, tx_take}, 0);
        check(sysclk_en && bclk_oe && fsync_oe, "R8", "sysclk both local",
              {sysclk_en, bclk_oe, fsync_oe}, 3'b111);

        // Table of loopback vectors, local clocks
        for (int v = 0; v < 6; v++) begin
            vec_t cv;
            int falls, b, mism, takes, cyc, f2, f3, ntx, nrx, idx;
            logic pb, pf, expb;
            logic [23:0] samp;
            cv = VECS[v];
            cfg_lj = cv.lj; cfg_mono = cv.mono; cfg_tx_size = cv.txs;
            cfg_rx_size = cv.rxs; cfg_div = cv.div; tx_left = cv.l; tx_right = cv.r;
            ntx = bits_of(cv.txs); nrx = bits_of(cv.rxs);
            do_reset();
            falls = 0; b = 0; mism = 0; takes = 0; cyc = 0; f2 = 0; f3 = 0;
            cap_n = 0;
            pb = bclk_out; pf = fsync_out;
            while (falls < 4) begin
                @(negedge clk);
                cyc++;
                if (pf && !fsync_out) begin
                    falls++;
                    if (falls == 2) f2 = cyc;
                    if (falls == 3) f3 = cyc;
                end
                if (pf != fsync_out) begin
                    b = -1;
                    if (pb == bclk_out || bclk_out) mism++; // R2: sync only with a falling bclk
                end
                if (!pb && bclk_out && falls >= 2) begin
                    b++;
                    idx  = cv.lj ? b : b - 1;
                    samp = (fsync_out && !cv.mono) ? cv.r : cv.l;
                    expb = tx_bit(samp, ntx, idx);
                    if (sd_out !== expb) mism++;
                end
                if (falls == 2 && tx_take) takes++;
                pb = bclk_out; pf = fsync_out;
            end
            check(f3 - f2 == 128 * (int'(cv.div) + 1), "R1", $sformatf("frame period vec%0d", v),
                  f3 - f2, 128 * (int'(cv.div) + 1));
            check(mism == 0, "R3", $sformatf("serial bits R2/R4/R5 vec%0d", v), mism, 0);
            check(takes == 1, "R10", $sformatf("take pulses vec%0d", v), takes, 1);
            check(cap_n > 0 && cap_l == 24'(rx_model(cv.l, ntx, nrx)), "R6",
                  $sformatf("rx left vec%0d", v), cap_l, rx_model(cv.l, ntx, nrx));
            check(cap_r == 24'(rx_model(cv.mono ? cv.l : cv.r, ntx, nrx)),
                  cv.mono ? "R5" : "R6", $sformatf("rx right vec%0d", v),
                  cap_r, rx_model(cv.mono ? cv.l : cv.r, ntx, nrx));
        end

        // R1: bit clock phase length at div=5
        begin
            int hi, lo;
            cfg_div = 4'd5; cfg_lj = 1'b1; cfg_mono = 1'b0;
            do_reset();
            while (bclk_out !== 1'b1) @(negedge clk);
            hi = 0;
            while (bclk_out === 1'b1) begin @(negedge clk); hi++; end
            lo = 0;
            while (bclk_out === 1'b0) begin @(negedge clk); lo++; end
            check(hi == 6 && lo == 6, "R1", "bclk phases", {hi[15:0], lo[15:0]}, {16'd6, 16'd6});
        end

        // R8/R7: mixed clocking
        cfg_bclk_local = 1'b1; cfg_fsync_local = 1'b0;
        @(negedge clk);
        check(!sysclk_en && bclk_oe && !fsync_oe, "R8", "mixed enables",
              {sysclk_en, bclk_oe, fsync_oe}, 3'b010);

        // R7: slave bit clock and frame sync
        begin
            int mism, pos, idx;
            logic [15:0] pat_l, pat_r;
            logic expb;
            logic [23:0] samp;
            pat_l = 16'hBEEF; pat_r = 16'h0F0F;
            cfg_bclk_local = 1'b0; cfg_fsync_local = 1'b0; cfg_lj = 1'b0;
            cfg_tx_size = 3'd1; cfg_rx_size = 3'd1; cfg_div = 4'd0;
            tx_left = 24'hFF1357; tx_right = 24'h002468;
            loop_en = 1'b0; bclk_in = 1'b0; fsync_in = 1'b1;
            do_reset();
            cap_n = 0; mism = 0;
            check(!bclk_oe && !fsync_oe && !sysclk_en, "R7", "slave enables",
                  {bclk_oe, fsync_oe, sysclk_en}, 0);
            for (int f = 0; f < 4; f++) begin
                for (int s = 0; s < 64; s++) begin
                    @(negedge clk);
                    bclk_in  = 1'b0;
                    fsync_in = (s >= 32);
                    pos = (s + 63) % 64;
                    idx = pos % 32;
                    gen_sd = (idx < 16) ? ((pos >= 32) ? pat_r[15-idx] : pat_l[15-idx]) : 1'b0;
                    repeat (8) @(negedge clk);
                    if (f >= 1) begin
                        samp = (pos >= 32) ? tx_right : tx_left;
                        expb = tx_bit(samp, 16, idx);
                        if (sd_out !== expb) mism++;
                    end
                    if (bclk_out !== 1'b0) mism++;
                    bclk_in = 1'b1;
                    repeat (7) @(negedge clk);
                end
            end
            check(mism == 0, "R7", "slave serial out", mism, 0);
            check(cap_n > 0 && cap_l == 24'h00BEEF, "R7", "slave rx left", cap_l, 24'h00BEEF);
            check(cap_r == 24'h000F0F, "R6", "slave rx right", cap_r, 24'h000F0F);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule